// File: doc/BRIEF.md
# I2S Full-Duplex Master with Two-Half Capture Buffer

This block is the serial audio master for a stereo codec link. It divides the system clock down to a bit clock and derives a word select from it. Both lines are outputs. Under that one frame timing it serialises a playback stereo pair onto an outgoing data line and deserialises a captured stereo pair from an incoming data line. Each channel sample is 24 bits of signed two's complement, sent most significant bit first.

Each captured stereo frame is stored in a circular buffer of `FRAMES` entries, which is split into a lower half and an upper half. When the last entry of a half is written, the block issues a one-cycle event. Downstream logic can then work on that half while the other half fills. A read port gives access to any entry. Each half has its own acknowledge input. If writing reaches a half whose event has not been acknowledged, a sticky overrun flag is set. Playback samples are taken from two parallel input ports once per frame.

Top module: `i2s_duplex_pingpong`

## Requirements
- R1: Out of reset `sclk` is low. It toggles every `CLK_DIV` system clocks, so one bit clock lasts 2*`CLK_DIV` cycles.
- R2: A frame is 64 bit clocks long and is made of two 32-bit slots. `ws` is low for the left slot and high for the right slot. It changes only on a falling edge of `sclk`.
- R3: In a slot, bit positions 1 to 24 (counted in bit clocks after the `ws` edge) carry the playback sample MSB first. Positions 0 and 25 to 31 are driven 0. `sdOut` changes only on a falling edge of `sclk`.
- R4: `txLeft` and `txRight` are latched on the falling `sclk` edge that opens each left slot. The first frame after reset sends all zeros.
- R5: `sdIn` is sampled on rising `sclk` edges at slot positions 1 to 24, MSB first. Values at every other position have no effect on the stored data.
- R6: Captured frame k is stored in entry k mod `FRAMES` as {left, right}, with left in bits 47:24. After the last entry, writing wraps to entry 0. `rdData` shows the entry selected by `rdAddr` with no clock delay.
- R7: `halfDone` pulses for one cycle, right after entry `FRAMES`/2-1 is written. `fullDone` pulses for one cycle, right after entry `FRAMES`-1 is written.
- R8: Each half has a pending flag. It is set by that half's event and cleared by its acknowledge (`ackLow`, `ackHigh`). If the first entry of a half is written while that half is still pending and is not acknowledged in the same cycle, `overrun` sets and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| txLeft | input | 24 | Left playback sample |
| txRight | input | 24 | Right playback sample |
| sdIn | input | 1 | Serial capture data |
| ackLow | input | 1 | Acknowledge for the lower half |
| ackHigh | input | 1 | Acknowledge for the upper half |
| rdAddr | input | 2 | Buffer read index |
| sclk | output | 1 | Bit clock |
| ws | output | 1 | Word select |
| sdOut | output | 1 | Serial playback data |
| rdData | output | 48 | Buffer entry {left, right} |
| halfDone | output | 1 | Lower half complete pulse |
| fullDone | output | 1 | Upper half complete pulse |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench drives random values into the padding positions of `sdIn`. A receiver that shifted beyond bit 24 would then corrupt the stored frames. Playback values change in the middle of a frame, which exposes a transmitter that reads its inputs live instead of latching them at the frame boundary; the first frame must come out as zeros. The run covers three buffer wraps, so a pointer that failed to wrap or an event fired from the wrong entry shows up as a mismatch on the read port or in the pulse timing. The acknowledges are then withheld, and `overrun` must rise on exactly the write that reaches a pending half and not before.

// File: rtl/i2s_pp_pkg.sv
package i2s_pp_pkg;
  typedef struct packed {
    logic load;      // load playback word at frame start
    logic shift;     // advance playback shifter
    logic sample;    // take one capture bit
    logic capLeft;   // left capture complete
    logic capRight;  // right capture complete, frame ready
  } strobe_t;
endpackage

// File: rtl/i2s_pp_ctrl.sv
module i2s_pp_ctrl
  import i2s_pp_pkg::*;
#(
  parameter int CLK_DIV  = 2,
  parameter int SLOT_W   = 32,
  parameter int SAMPLE_W = 24
) (
  input  logic    clk,
  input  logic    rstN,
  output logic    sclk,
  output logic    ws,
  output strobe_t stb
);
  localparam int FRAME_BITS = 2 * SLOT_W;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int DIV_W      = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DIV_W-1:0]  divCnt;
  logic [POS_W-1:0]  pos;
  logic              sclkQ;
  logic              tick, riseEdge, fallEdge, isRight;
  logic [POS_W-2:0]  slotPos;

  assign tick     = (divCnt == DIV_W'(CLK_DIV - 1));
  assign riseEdge = tick && !sclkQ;
  assign fallEdge = tick && sclkQ;
  assign isRight  = pos[POS_W-1];
  assign slotPos  = pos[POS_W-2:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      sclkQ  <= 1'b0;
      pos    <= '0;
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) sclkQ <= ~sclkQ;
      if (fallEdge) pos <= pos + 1'b1;
    end
  end

  always_comb begin
    stb.load     = fallEdge && (pos == POS_W'(FRAME_BITS - 1));
    stb.shift    = fallEdge && !stb.load;
    stb.sample   = riseEdge && (slotPos >= (POS_W-1)'(1)) &&
                   (slotPos <= (POS_W-1)'(SAMPLE_W));
    stb.capLeft  = riseEdge && !isRight && (slotPos == (POS_W-1)'(SAMPLE_W));
    stb.capRight = riseEdge &&  isRight && (slotPos == (POS_W-1)'(SAMPLE_W));
  end

  assign sclk = sclkQ;
  assign ws   = isRight;

  p_sclk_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |=> $stable(sclk));
  p_ws_on_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ws) |-> $fell(sclk));
endmodule

// File: rtl/i2s_pp_datapath.sv
module i2s_pp_datapath
  import i2s_pp_pkg::*;
#(
  parameter int SLOT_W   = 32,
  parameter int SAMPLE_W = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic                  sclk,
  input  logic [SAMPLE_W-1:0]   txLeft,
  input  logic [SAMPLE_W-1:0]   txRight,
  input  logic                  sdIn,
  output logic                  sdOut,
  output logic [2*SAMPLE_W-1:0] frameData
);
  localparam int FRAME_BITS = 2 * SLOT_W;
  localparam int PAD        = SLOT_W - SAMPLE_W - 1;

  logic [FRAME_BITS-1:0] txShift;
  logic [SAMPLE_W-1:0]   rxShift, rxNext, leftHold;

  assign rxNext = {rxShift[SAMPLE_W-2:0], sdIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift  <= '0;
      rxShift  <= '0;
      leftHold <= '0;
    end else begin
      if (stb.load)
        txShift <= {1'b0, txLeft, {PAD{1'b0}}, 1'b0, txRight, {PAD{1'b0}}};
      else if (stb.shift)
        txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
      if (stb.sample) rxShift <= rxNext;
      if (stb.capLeft) leftHold <= rxNext;
    end
  end

  assign sdOut     = txShift[FRAME_BITS-1];
  assign frameData = {leftHold, rxNext};

  p_sd_on_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdOut) |-> $fell(sclk));
endmodule

// File: rtl/i2s_pp_buffer.sv
module i2s_pp_buffer #(
  parameter int FRAMES = 4,
  parameter int DATA_W = 48,
  parameter int AW     = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic [DATA_W-1:0] frameData,
  input  logic              ackLow,
  input  logic              ackHigh,
  input  logic [AW-1:0]     rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              halfDone,
  output logic              fullDone,
  output logic              overrun
);
  localparam int HALF = FRAMES / 2;

  logic [DATA_W-1:0] mem [FRAMES];
  logic [AW-1:0]     wrPtr;
  logic              pendLow, pendHigh;
  logic              atLowEnd, atHighEnd, hitLow, hitHigh;

  assign atLowEnd  = frameValid && (wrPtr == AW'(HALF - 1));
  assign atHighEnd = frameValid && (wrPtr == AW'(FRAMES - 1));
  assign hitLow    = frameValid && (wrPtr == '0) && pendLow && !ackLow;
  assign hitHigh   = frameValid && (wrPtr == AW'(HALF)) && pendHigh && !ackHigh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < FRAMES; i++) mem[i] <= '0;
      wrPtr    <= '0;
      pendLow  <= 1'b0;
      pendHigh <= 1'b0;
      halfDone <= 1'b0;
      fullDone <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      halfDone <= atLowEnd;
      fullDone <= atHighEnd;
      if (frameValid) begin
        mem[wrPtr] <= frameData;
        wrPtr      <= atHighEnd ? '0 : wrPtr + 1'b1;
      end
      if (atLowEnd) pendLow <= 1'b1;
      else if (ackLow) pendLow <= 1'b0;
      if (atHighEnd) pendHigh <= 1'b1;
      else if (ackHigh) pendHigh <= 1'b0;
      if (hitLow || hitHigh) overrun <= 1'b1;
    end
  end

  assign rdData = mem[rdAddr];

  p_half_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    halfDone |=> !halfDone);
  p_full_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    fullDone |=> !fullDone);
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);
  p_overrun_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(frameValid));
endmodule

// File: rtl/i2s_duplex_pingpong.sv
module i2s_duplex_pingpong
  import i2s_pp_pkg::*;
#(
  parameter int CLK_DIV  = 2,
  parameter int SLOT_W   = 32,
  parameter int SAMPLE_W = 24,
  parameter int FRAMES   = 4,
  parameter int AW       = $clog2(FRAMES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [SAMPLE_W-1:0]   txLeft,
  input  logic [SAMPLE_W-1:0]   txRight,
  input  logic                  sdIn,
  input  logic                  ackLow,
  input  logic                  ackHigh,
  input  logic [AW-1:0]         rdAddr,
  output logic                  sclk,
  output logic                  ws,
  output logic                  sdOut,
  output logic [2*SAMPLE_W-1:0] rdData,
  output logic                  halfDone,
  output logic                  fullDone,
  output logic                  overrun
);
  strobe_t               stb;
  logic [2*SAMPLE_W-1:0] frameData;

  i2s_pp_ctrl #(.CLK_DIV(CLK_DIV), .SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .ws(ws), .stb(stb));

  i2s_pp_datapath #(.SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .sclk(sclk), .txLeft(txLeft),
    .txRight(txRight), .sdIn(sdIn), .sdOut(sdOut), .frameData(frameData));

  i2s_pp_buffer #(.FRAMES(FRAMES), .DATA_W(2*SAMPLE_W), .AW(AW)) uBuf (
    .clk(clk), .rstN(rstN), .frameValid(stb.capRight), .frameData(frameData),
    .ackLow(ackLow), .ackHigh(ackHigh), .rdAddr(rdAddr), .rdData(rdData),
    .halfDone(halfDone), .fullDone(fullDone), .overrun(overrun));
endmodule

// File: tb/i2s_duplex_pingpong_test.sv
module i2s_duplex_pingpong_test;
  localparam int CLK_DIV = 2;
  localparam int FRAMES  = 4;
  localparam int HALF    = FRAMES / 2;
  localparam int NEDGES  = 12 * 64 * 2 * CLK_DIV;
  localparam int ACK_STOP = 6;

  logic clk = 0, rstN = 0, sdIn = 0, ackLow = 0, ackHigh = 0;
  logic [23:0] txLeft = '0, txRight = '0;
  logic [1:0]  rdAddr = '0;
  logic sclk, ws, sdOut, halfDone, fullDone, overrun;
  logic [47:0] rdData;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [47:0] expMem [FRAMES];

  always #5 clk = ~clk;

  i2s_duplex_pingpong uut (
    .clk(clk), .rstN(rstN), .txLeft(txLeft), .txRight(txRight), .sdIn(sdIn),
    .ackLow(ackLow), .ackHigh(ackHigh), .rdAddr(rdAddr), .sclk(sclk), .ws(ws),
    .sdOut(sdOut), .rdData(rdData), .halfDone(halfDone), .fullDone(fullDone),
    .overrun(overrun));

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] txPat(int f, bit right);
    return right ? 24'(f * 32'h0a5f13 + 32'h7ffff1) : 24'(f * 32'h13579b + 32'h800001);
  endfunction
  function automatic logic [23:0] rxPat(int f, bit right);
    return right ? 24'(f * 32'h2468ac + 32'hc00003) : 24'(f * 32'h0f1e2d + 32'h3c5a01);
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ackLCnt = 0, ackHCnt = 0;
    bit pendL = 0, pendH = 0, ovrE = 0;
    for (int i = 0; i < FRAMES; i++) expMem[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    // reset state
    chk("R1", "sclk in reset", 64'(sclk), 0);
    chk("R2", "ws in reset", 64'(ws), 0);
    chk("R3", "sdOut in reset", 64'(sdOut), 0);
    chk("R7", "halfDone in reset", 64'(halfDone), 0);
    chk("R8", "overrun in reset", 64'(overrun), 0);
    rstN = 1;
    for (int n = 0; n < NEDGES; n++) begin
      bit isTick, rising, wr, prevAckL, prevAckH, expHalf, expFull, txBit;
      int ticks, falls, p, f, s, slot;
      logic [23:0] smp;
      @(posedge clk);
      #1;
      prevAckL = ackLow; prevAckH = ackHigh;
      isTick = ((n + 1) % CLK_DIV) == 0;
      ticks  = (n + 1) / CLK_DIV;
      rising = isTick && ((ticks - 1) % 2 == 0);
      falls  = ticks / 2;
      p = falls % 64;
      f = falls / 64;
      wr = rising && (p == 32 + 24);
      slot = f % FRAMES;
      expHalf = 0; expFull = 0;
      if (wr) begin
        if (slot == 0 && pendL && !prevAckL) ovrE = 1;
        if (slot == HALF && pendH && !prevAckH) ovrE = 1;
        expMem[slot] = {rxPat(f, 0), rxPat(f, 1)};
        expHalf = (slot == HALF - 1);
        expFull = (slot == FRAMES - 1);
      end
      if (expHalf) pendL = 1; else if (prevAckL) pendL = 0;
      if (expFull) pendH = 1; else if (prevAckH) pendH = 0;
      // playback expectation
      s = p % 32;
      txBit = 0;
      if (f >= 1 && s >= 1 && s <= 24) begin
        smp = txPat(f - 1, p >= 32);
        txBit = smp[24 - s];
      end
      chk("R1", "sclk", 64'(sclk), 64'(ticks % 2));
      chk("R2", "ws", 64'(ws), 64'(p >= 32));
      chk(f == 0 ? "R4" : "R3", "sdOut", 64'(sdOut), 64'(txBit));
      chk("R7", "halfDone", 64'(halfDone), 64'(expHalf));
      chk("R7", "fullDone", 64'(fullDone), 64'(expFull));
      chk("R8", "overrun", 64'(overrun), 64'(ovrE));
      chk(wr ? "R5" : "R6", "rdData", 64'(rdData), 64'(expMem[rdAddr]));
      // next inputs
      if (s >= 1 && s <= 24) begin
        smp = rxPat(f, p >= 32);
        sdIn = smp[24 - s];
      end else begin
        sdIn = ((n * 7 + p) % 3) == 0;   // padding noise, must be ignored (R5)
      end
      if (p == 40) begin
        txLeft  = txPat(f, 0);
        txRight = txPat(f, 1);
      end
      if (expHalf && f < ACK_STOP) ackLCnt = 3;
      if (expFull && f < ACK_STOP) ackHCnt = 3;
      ackLow = 0; ackHigh = 0;
      if (ackLCnt > 0) begin ackLCnt--; ackLow = (ackLCnt == 0); end
      if (ackHCnt > 0) begin ackHCnt--; ackHigh = (ackHCnt == 0); end
      rdAddr = 2'(n % FRAMES);
    end
    chk("R8", "overrun after withheld acks", 64'(overrun), 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule